// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers up to eight interrupt request lines and presents them to a processor as one interrupt output. A host programs it through a byte-wide register port. One address bit selects either the command port or the data port. The block latches each rising request edge, applies a host-controlled mask, and picks the most urgent line when the processor acknowledges. It then returns a vector equal to a programmed base with the line index in its low bits.

Programming is a short protocol. The command byte 0x11 arms a setup sequence, which consumes the next three data-port writes. Outside that sequence the data port reads and writes the mask. The command byte 0x20 closes the current service so that later requests can be signalled again. Priority is fixed, with line 0 the most urgent. Only one line is in service at a time.

The host port, the request lines and the acknowledge strobe are plain control pins. The vector leaves on a one-cycle valid pulse with no ready input, so the block never holds it back.

Top module: `irq_ctl8`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low, the mask reads back 0xFF (all lines blocked) and the vector base is 0x00.
- R2: Writing 0x11 to the command port (`a0`=0) arms the setup sequence. The next three data-port writes (`a0`=1) are taken in order as the vector base, then the cascade byte, then the mode byte. After that the data port returns to mask access.
- R3: The cascade and mode byte values have no effect on the vectors returned or on the mask.
- R4: A data-port write made while the setup sequence is in progress never changes the mask. The mask is the same after setup as before it.
- R5: Outside setup, a data-port write loads the 8-bit mask, where bit k set blocks line k. A read with `rd`=1 and `a0`=1 returns the mask on `rdata`. Any other read returns 0x00.
- R6: A rising edge on `irq_in[k]` sets pending bit k even when line k is masked. A request held high does not trigger again. A masked pending line signals once it is unmasked.
- R7: `int_out` is high exactly when some pending line is unmasked and no line is in service. It becomes visible in the cycle after the clock edge that captures the request edge.
- R8: When `inta` is sampled high while `int_out` is high, the block takes the lowest-index unmasked pending line. One cycle later `vec_valid` pulses for one cycle, with `vec_out` = {base[7:3], index[2:0]}.
- R9: An acknowledge clears the chosen pending bit, puts that line in service and drops `int_out` until service ends. An acknowledge while `int_out` is low produces no `vec_valid`.
- R10: Writing 0x20 to the command port ends the service in progress. Command bytes other than 0x11 and 0x20 have no effect.
- R11: The low three bits of the programmed base are ignored when the vector is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines; a rising edge latches a request |
| wr | input | 1 | Host write strobe, one write per cycle it is high |
| rd | input | 1 | Host read enable |
| a0 | input | 1 | Port select: 0 is the command port, 1 is the data port |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (mask or 0x00) |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge strobe, one cycle |
| vec_valid | output | 1 | One-cycle pulse marking `vec_out` valid |
| vec_out | output | 8 | Vector of the line taken into service |

## Verification
The assertions assume that `inta` arrives as a single-cycle strobe and that the host never writes in the same cycle as an acknowledge. The vector-base check compares against the base one cycle earlier, so it also assumes the base is not reprogrammed across an acknowledge. The bench drives every strobe for exactly one cycle on the falling edge and keeps host writes and acknowledges in separate cycles. It lowers every request line before raising it again, so that each intended edge is a clean rise.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam logic [7:0] CMD_SETUP = 8'h11;
  localparam logic [7:0] CMD_EOI   = 8'h20;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BASE = 2'd1,
    SQ_CASC = 2'd2,
    SQ_MODE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_prog_seq.sv
module irq_prog_seq
  import irq_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] base,
  output logic          eoi
);
  seq_state_t    st_q;
  logic [DW-1:0] mask_q, base_q;
  logic          cmd_wr, dat_wr;

  assign cmd_wr = wr && !a0;
  assign dat_wr = wr && a0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      mask_q <= '1;
      base_q <= '0;
    end else begin
      if (cmd_wr && wdata == CMD_SETUP) begin
        st_q <= SQ_BASE;
      end else if (dat_wr) begin
        unique case (st_q)
          SQ_IDLE: mask_q <= wdata;
          SQ_BASE: begin base_q <= wdata; st_q <= SQ_CASC; end
          SQ_CASC: st_q <= SQ_MODE;
          SQ_MODE: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign mask = mask_q;
  assign base = base_q;
  assign eoi  = cmd_wr && (wdata == CMD_EOI);

  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && st_q != SQ_IDLE) |=> $stable(mask_q));
  a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cmd_wr && st_q == SQ_BASE) |=> (base_q == $past(wdata)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_track.sv
module irq_req_track #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  mask,
  input  logic          ack,
  input  logic          eoi,
  output logic          signal,
  output logic          grant,
  output logic [IW-1:0] grant_idx
);
  logic [N-1:0] prev_q, pend_q, isr_q, rise, cand, take;
  logic         any;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= irq_in[g];
    end
    assign rise[g] = irq_in[g] && !prev_q[g];
    assign take[g] = grant && (grant_idx == IW'(g));
  end

  assign cand = pend_q & ~mask;

  irq_prio_pick #(.N(N)) u_pick (.req(cand), .any(any), .idx(grant_idx));

  assign signal = any && (isr_q == '0);
  assign grant  = signal && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take) | rise;
      isr_q  <= (eoi ? '0 : isr_q) | take;
    end
  end

  a_r9_single_service: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q));
  a_r9_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> $onehot(isr_q));
  a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !grant) |=> (isr_q == '0));
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8 #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          wr,
  input  logic          rd,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          int_out,
  input  logic          inta,
  output logic          vec_valid,
  output logic [DW-1:0] vec_out
);
  logic [DW-1:0] mask, base;
  logic          eoi, grant;
  logic [IW-1:0] gidx;
  logic          vv_q;
  logic [DW-1:0] vec_q;

  irq_prog_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(wr), .a0(a0), .wdata(wdata),
    .mask(mask), .base(base), .eoi(eoi)
  );

  irq_req_track #(.N(N)) u_trk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask[N-1:0]),
    .ack(inta), .eoi(eoi), .signal(int_out), .grant(grant), .grant_idx(gidx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      vv_q <= grant;
      if (grant) vec_q <= {base[DW-1:IW], gidx};
    end
  end

  assign vec_valid = vv_q;
  assign vec_out   = vec_q;
  assign rdata     = (rd && a0) ? mask : '0;

  a_r8_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[DW-1:IW] == $past(base[DW-1:IW])));
  a_r9_ack_drops_int: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !eoi) |=> !int_out);
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
endmodule

// File: tb/sim_irq_ctl8.sv
`timescale 1ns/1ps
module sim_irq_ctl8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, wdata = '0, rdata, vec_out;
  logic wr = 0, rd = 0, a0 = 0, inta = 0, int_out, vec_valid;
  int checks = 0, errors = 0;
  logic [7:0] base_m = 8'h00;

  always #2.5 clk = ~clk;

  irq_ctl8 u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr(wr), .rd(rd),
    .a0(a0), .wdata(wdata), .rdata(rdata), .int_out(int_out), .inta(inta),
    .vec_valid(vec_valid), .vec_out(vec_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic port, input logic [7:0] d);
    @(negedge clk); wr = 1; a0 = port; wdata = d;
    @(negedge clk); wr = 0; a0 = 0; wdata = '0;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    @(negedge clk); rd = 1; a0 = 1; #1 v = rdata;
    rd = 0; a0 = 0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk); irq_in = irq_in | lines;
    @(negedge clk); irq_in = irq_in & ~lines;
    @(negedge clk);
  endtask

  task automatic ack(output bit vv, output logic [7:0] v);
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0; vv = vec_valid; v = vec_out;
  endtask

  task automatic setup(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    hwrite(0, 8'h11); hwrite(1, b); hwrite(1, c); hwrite(1, m);
    base_m = b;
  endtask

  function automatic logic [7:0] exp_vec(input int line);
    return {base_m[7:3], 3'(line)};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, m;
    bit vv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(int_out == 0, "R1 int_out", int_out, 0);
    chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
    rd_mask(m); chk(m == 8'hFF, "R1 mask", m, 8'hFF);
    // R5 mask write/read, read of command port
    hwrite(1, 8'h00); rd_mask(m); chk(m == 8'h00, "R5 mask", m, 0);
    @(negedge clk); rd = 1; a0 = 0; #1 chk(rdata == 0, "R5 cmd read", rdata, 0); rd = 0;
    // R1 base 0 and R8 vector per line
    for (int k = 0; k < 8; k++) begin
      pulse(8'(1 << k));
      chk(int_out == 1, "R7 raise", int_out, 1);
      ack(vv, v);
      chk(vv && v == exp_vec(k), "R1 R8 vector", v, exp_vec(k));
      chk(int_out == 0, "R9 drop", int_out, 0);
      hwrite(0, 8'h20);
    end
    // R2 R3 R11 setup with several bases and odd cascade/mode bytes
    hwrite(1, 8'h3C);
    for (int b = 0; b < 8; b++) begin
      setup(8'(b * 37 + 5), 8'(b * 91), 8'(8'hFF - b));
      rd_mask(m); chk(m == 8'h3C, "R4 mask after setup", m, 8'h3C);
      hwrite(1, 8'h00);
      for (int k = 0; k < 8; k++) begin
        pulse(8'(1 << k));
        ack(vv, v);
        chk(vv && v == exp_vec(k), "R2 R3 R11 vector", v, exp_vec(k));
        hwrite(0, 8'h20);
      end
      hwrite(1, 8'h3C);
    end
    // R4 mask readable mid-setup and unchanged
    hwrite(0, 8'h11); hwrite(1, 8'h48);
    rd_mask(m); chk(m == 8'h3C, "R4 mid-setup", m, 8'h3C);
    hwrite(1, 8'h04); hwrite(1, 8'h01); base_m = 8'h48;
    rd_mask(m); chk(m == 8'h3C, "R4 end", m, 8'h3C);
    hwrite(1, 8'h5A); rd_mask(m); chk(m == 8'h5A, "R2 back to mask", m, 8'h5A);
    // R6 masked pending, signals later
    hwrite(1, 8'hFF);
    pulse(8'h20);
    chk(int_out == 0, "R6 masked", int_out, 0);
    hwrite(1, 8'h00);
    chk(int_out == 1, "R6 unmask", int_out, 1);
    ack(vv, v); chk(vv && v == exp_vec(5), "R6 vector", v, exp_vec(5));
    hwrite(0, 8'h20);
    // R6 held level does not retrigger
    @(negedge clk); irq_in = 8'h08; @(negedge clk); @(negedge clk);
    ack(vv, v); chk(vv && v == exp_vec(3), "R6 held vector", v, exp_vec(3));
    hwrite(0, 8'h20); @(negedge clk);
    chk(int_out == 0, "R6 no retrigger", int_out, 0);
    irq_in = 0; @(negedge clk);
    // R9 ack with nothing pending
    ack(vv, v); chk(vv == 0, "R9 idle ack", vv, 0);
    // R10 other command bytes ignored
    pulse(8'h81); ack(vv, v);
    chk(vv && v == exp_vec(0), "R8 lowest", v, exp_vec(0));
    hwrite(0, 8'h33);
    chk(int_out == 0, "R10 other cmd", int_out, 0);
    hwrite(0, 8'h20);
    chk(int_out == 1, "R10 eoi", int_out, 1);
    ack(vv, v); hwrite(0, 8'h20);
    // R8 R7 sweep over all masks with all lines pending
    for (int mm = 0; mm < 256; mm++) begin
      int low;
      pulse(8'hFF);
      hwrite(1, 8'(mm));
      low = -1;
      for (int k = 7; k >= 0; k--) if (!mm[k]) low = k;
      chk(int_out == (low >= 0), "R7 sweep", int_out, low >= 0);
      if (low >= 0) begin
        ack(vv, v);
        chk(vv && v == exp_vec(low), "R8 sweep", v, exp_vec(low));
        chk(int_out == 0, "R9 sweep", int_out, 0);
        hwrite(0, 8'h20);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule